// File: doc/BRIEF.md
# Evicted register pattern compressor

This block sits between a per-core register staging store and the backing data cache. Every multi-lane register value that the staging store evicts enters the compressor first. If every lane is zero, or if the lanes form an arithmetic sequence with a constant stride, the value is kept in compact form in a small associative line store. A line holds the owner tag (warp and register number), a pattern code, a 32-bit base and a 32-bit stride. Any other value goes to the backing cache unchanged.

When the staging store later preloads a register, the compressor searches its lines first. On a hit it rebuilds the full lane vector in one step, returns it and frees the line. On a miss it answers with a miss flag and forwards the read to the backing cache. When a compressible value arrives while every line is in use, the least recently written line is expanded and written back to the backing cache, and the new value takes its place.

Top module: `evict_pattern_comp`

## Requirements
- R1: After reset no line is valid. All output valid strobes are 0, and a preload of any tag misses.
- R2: An evicted value whose lanes are all zero is kept as a line and does not reach the backing cache. A later preload of that tag returns hit=1 and all-zero lanes.
- R3: An evicted value with lane[i] = lane[0] + i*(lane[1]-lane[0]) modulo 2^32 for every lane i is kept as a line. This includes wrapping and negative strides. A preload returns the identical vector.
- R4: An evicted value that fits neither pattern appears unchanged on the backing write port, with its warp and register tag, one cycle after the eviction.
- R5: A preload miss gives pl_rsp_valid=1 with pl_rsp_hit=0. In the same cycle it raises a backing read request for the same warp and register.
- R6: A preload hit frees the line, so a second preload of the same tag misses.
- R7: Evicting a tag that already has a line replaces that line in place when the new value is compressible. Otherwise the line is dropped and the new value is forwarded as in R4.
- R8: The store holds LINES lines (48 by default). A compressible eviction of a new tag into a full store writes the least recently written line back as its expanded vector, with its own tag.
- R9: Re-evicting a resident tag makes it the most recently written line for the R8 replacement order.
- R10: When a preload and an eviction arrive in the same cycle, the preload sees the contents from before that cycle. A line freed by the preload hit is reused without a write-back. If both name the same tag, the response carries the old value and the line then holds the new one.
- R11: All outputs are registered. A response or backing request appears exactly one cycle after the input that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Eviction present |
| ev_warp | input | WARP_W | Warp of the evicted register |
| ev_reg | input | REG_W | Register number of the evicted register |
| ev_data | input | LANES*DW | Evicted lane vector, lane 0 in the low bits |
| pl_valid | input | 1 | Preload request present |
| pl_warp | input | WARP_W | Warp of the requested register |
| pl_reg | input | REG_W | Register number requested |
| pl_rsp_valid | output | 1 | Preload response |
| pl_rsp_hit | output | 1 | Response was served from a compressed line |
| pl_rsp_warp | output | WARP_W | Warp of the response |
| pl_rsp_reg | output | REG_W | Register of the response |
| pl_rsp_data | output | LANES*DW | Rebuilt lane vector (valid on hit) |
| bk_wr_valid | output | 1 | Write to the backing cache |
| bk_wr_warp | output | WARP_W | Warp of the written register |
| bk_wr_reg | output | REG_W | Register number written |
| bk_wr_data | output | LANES*DW | Full lane vector written |
| bk_rd_valid | output | 1 | Read request to the backing cache (preload miss) |
| bk_rd_warp | output | WARP_W | Warp requested |
| bk_rd_reg | output | REG_W | Register requested |

## Verification
The bench aims at near-miss vectors, such as a stride sequence with one lane off or a stride that wraps past 2^32. A classifier that checked too few lanes would swallow the near-miss value, and one that mishandled wrapping would lose the wrapping sequence. Both show up as a missing backing write or a wrong rebuilt vector. It fills the store and refreshes one tag before it overflows the store. A replacement order that ignored refreshes would write back the wrong tag. Same-cycle preload and eviction, both on distinct tags and on one tag, expose a design that freed lines in the wrong order: it would emit a needless write-back or answer with the new value instead of the old one. A long random mix over a small tag pool then exercises re-eviction and invalidation against a reference model.

// File: rtl/ecmp_pkg.sv
package ecmp_pkg;
  typedef enum logic [1:0] {
    PAT_NONE   = 2'b00,
    PAT_ZERO   = 2'b01,
    PAT_STRIDE = 2'b10
  } pat_e;
endpackage

// File: rtl/ecmp_classify.sv
// Decides whether a lane vector is all zero or a constant-stride sequence.
module ecmp_classify
  import ecmp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 32
) (
  input  logic [LANES*DW-1:0] data,
  output pat_e                pat,
  output logic [DW-1:0]       base,
  output logic [DW-1:0]       stride
);
  // lane i predicted from base and stride, wrapping modulo 2^DW
  function automatic logic lane_fits(input logic [LANES*DW-1:0] v, input int i,
                                     input logic [DW-1:0] b, input logic [DW-1:0] s);
    return v[i*DW +: DW] == (b + DW'(i) * s);
  endfunction

  logic [DW-1:0] b0, s0;
  logic          all_fit, all_zero;

  always_comb begin
    b0       = data[0 +: DW];
    s0       = data[DW +: DW] - b0;
    all_zero = ~|data;
    all_fit  = 1'b1;
    for (int i = 2; i < LANES; i++) all_fit = all_fit & lane_fits(data, i, b0, s0);
    if (all_zero) begin
      pat = PAT_ZERO;   base = '0; stride = '0;
    end else if (all_fit) begin
      pat = PAT_STRIDE; base = b0; stride = s0;
    end else begin
      pat = PAT_NONE;   base = '0; stride = '0;
    end
  end
endmodule

// File: rtl/ecmp_expand.sv
// Rebuilds every lane of a compressed line at once.
module ecmp_expand
  import ecmp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 32
) (
  input  pat_e                pat,
  input  logic [DW-1:0]       base,
  input  logic [DW-1:0]       stride,
  output logic [LANES*DW-1:0] data
);
  function automatic logic [DW-1:0] lane_value(input logic [DW-1:0] b,
                                               input logic [DW-1:0] s, input int i);
    return b + DW'(i) * s;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data[g*DW +: DW] = (pat == PAT_STRIDE) ? lane_value(base, stride, g) : '0;
  end
endmodule

// File: rtl/ecmp_match.sv
// Fully associative tag search across all lines.
module ecmp_match #(
  parameter int ENTRIES = 48,
  parameter int KEY_W   = 11,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES*KEY_W-1:0] keys,
  input  logic [ENTRIES-1:0]       valid,
  input  logic [KEY_W-1:0]         key,
  output logic [ENTRIES-1:0]       vec,
  output logic [IDX_W-1:0]         idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign vec[g] = valid[g] && (keys[g*KEY_W +: KEY_W] == key);
  end

  always_comb begin
    idx = '0;
    for (int j = 0; j < ENTRIES; j++)
      if (vec[j]) idx = idx | IDX_W'(j);
  end
endmodule

// File: rtl/evict_pattern_comp.sv
module evict_pattern_comp
  import ecmp_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DW     = 32,
  parameter int LINES  = 48,
  parameter int WARP_W = 5,
  parameter int REG_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_valid,
  input  logic [WARP_W-1:0]     ev_warp,
  input  logic [REG_W-1:0]      ev_reg,
  input  logic [LANES*DW-1:0]   ev_data,
  input  logic                  pl_valid,
  input  logic [WARP_W-1:0]     pl_warp,
  input  logic [REG_W-1:0]      pl_reg,
  output logic                  pl_rsp_valid,
  output logic                  pl_rsp_hit,
  output logic [WARP_W-1:0]     pl_rsp_warp,
  output logic [REG_W-1:0]      pl_rsp_reg,
  output logic [LANES*DW-1:0]   pl_rsp_data,
  output logic                  bk_wr_valid,
  output logic [WARP_W-1:0]     bk_wr_warp,
  output logic [REG_W-1:0]      bk_wr_reg,
  output logic [LANES*DW-1:0]   bk_wr_data,
  output logic                  bk_rd_valid,
  output logic [WARP_W-1:0]     bk_rd_warp,
  output logic [REG_W-1:0]      bk_rd_reg
);
  localparam int VEC_W = LANES * DW;
  localparam int TAG_W = WARP_W + REG_W;
  localparam int IDX_W = $clog2(LINES);
  localparam int AGE_W = $clog2(LINES + 1);
  localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(LINES - 1);

  // line store
  logic [LINES-1:0] valid_q;
  logic [AGE_W-1:0] age_q    [LINES];
  logic [TAG_W-1:0] tag_q    [LINES];
  pat_e             pat_q    [LINES];
  logic [DW-1:0]    base_q   [LINES];
  logic [DW-1:0]    stride_q [LINES];

  logic [LINES*TAG_W-1:0] tag_flat;
  for (genvar g = 0; g < LINES; g++) begin : g_pack
    assign tag_flat[g*TAG_W +: TAG_W] = tag_q[g];
  end

  logic [TAG_W-1:0] ev_tag, pl_tag;
  assign ev_tag = {ev_warp, ev_reg};
  assign pl_tag = {pl_warp, pl_reg};

  // lookups
  logic [LINES-1:0] ev_vec, pl_vec;
  logic [IDX_W-1:0] idx_e, idx_p;
  logic             hit_e, hit_p;

  ecmp_match #(.ENTRIES(LINES), .KEY_W(TAG_W)) u_match_ev (
    .keys(tag_flat), .valid(valid_q), .key(ev_tag), .vec(ev_vec), .idx(idx_e));
  ecmp_match #(.ENTRIES(LINES), .KEY_W(TAG_W)) u_match_pl (
    .keys(tag_flat), .valid(valid_q), .key(pl_tag), .vec(pl_vec), .idx(idx_p));

  assign hit_e = |ev_vec;
  assign hit_p = |pl_vec;

  // classification of the incoming value
  pat_e          c_pat;
  logic [DW-1:0] c_base, c_stride;
  logic          comp;

  ecmp_classify #(.LANES(LANES), .DW(DW)) u_classify (
    .data(ev_data), .pat(c_pat), .base(c_base), .stride(c_stride));
  assign comp = (c_pat != PAT_NONE);

  // internal events, named for the checker
  logic pl_inval, ev_inval, ev_touch, victim_wb;
  assign pl_inval = pl_valid && hit_p && !(ev_valid && hit_e && (idx_e == idx_p));
  assign ev_inval = ev_valid && hit_e && !comp;
  assign ev_touch = ev_valid && comp;

  // stage 1: frees from preload hit and dropped re-eviction
  logic [LINES-1:0] v1;
  logic [AGE_W-1:0] a1 [LINES];
  logic [AGE_W-1:0] dec;
  logic             full1;
  logic [IDX_W-1:0] free_idx, victim_idx, tgt;

  always_comb begin
    v1 = valid_q;
    if (pl_inval) v1[idx_p] = 1'b0;
    if (ev_inval) v1[idx_e] = 1'b0;
    for (int j = 0; j < LINES; j++) begin
      dec   = AGE_W'(pl_inval && (age_q[j] > age_q[idx_p]))
            + AGE_W'(ev_inval && (age_q[j] > age_q[idx_e]));
      a1[j] = age_q[j] - dec;
    end
    full1      = &v1;
    free_idx   = '0;
    victim_idx = '0;
    for (int j = LINES - 1; j >= 0; j--) begin
      if (!v1[j]) free_idx = IDX_W'(j);
      if (v1[j] && (a1[j] == AGE_OLDEST)) victim_idx = IDX_W'(j);
    end
    tgt = hit_e ? idx_e : (full1 ? victim_idx : free_idx);
  end

  assign victim_wb = ev_touch && !hit_e && full1;

  // stage 2: the touched line becomes most recent
  logic [LINES-1:0] v2;
  logic [AGE_W-1:0] a2 [LINES];
  logic [AGE_W-1:0] touch_age;

  always_comb begin
    touch_age = v1[tgt] ? a1[tgt] : AGE_W'($countones(v1));
    v2 = v1;
    for (int j = 0; j < LINES; j++) begin
      a2[j] = a1[j];
      if (ev_touch) begin
        if (IDX_W'(j) == tgt)                    a2[j] = '0;
        else if (v1[j] && (a1[j] < touch_age))   a2[j] = a1[j] + 1'b1;
      end
    end
    if (ev_touch) v2[tgt] = 1'b1;
  end

  // expansions for preload response and victim write-back
  logic [VEC_W-1:0] exp_pl, exp_vic;

  ecmp_expand #(.LANES(LANES), .DW(DW)) u_expand_pl (
    .pat(pat_q[idx_p]), .base(base_q[idx_p]), .stride(stride_q[idx_p]), .data(exp_pl));
  ecmp_expand #(.LANES(LANES), .DW(DW)) u_expand_vic (
    .pat(pat_q[victim_idx]), .base(base_q[victim_idx]), .stride(stride_q[victim_idx]),
    .data(exp_vic));

  // state update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int j = 0; j < LINES; j++) begin
        age_q[j]    <= '0;
        tag_q[j]    <= '0;
        pat_q[j]    <= PAT_NONE;
        base_q[j]   <= '0;
        stride_q[j] <= '0;
      end
    end else begin
      valid_q <= v2;
      for (int j = 0; j < LINES; j++) age_q[j] <= a2[j];
      if (ev_touch) begin
        tag_q[tgt]    <= ev_tag;
        pat_q[tgt]    <= c_pat;
        base_q[tgt]   <= c_base;
        stride_q[tgt] <= c_stride;
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pl_rsp_valid <= 1'b0;
      pl_rsp_hit   <= 1'b0;
      pl_rsp_warp  <= '0;
      pl_rsp_reg   <= '0;
      pl_rsp_data  <= '0;
      bk_wr_valid  <= 1'b0;
      bk_wr_warp   <= '0;
      bk_wr_reg    <= '0;
      bk_wr_data   <= '0;
      bk_rd_valid  <= 1'b0;
      bk_rd_warp   <= '0;
      bk_rd_reg    <= '0;
    end else begin
      pl_rsp_valid <= pl_valid;
      pl_rsp_hit   <= pl_valid && hit_p;
      pl_rsp_warp  <= pl_warp;
      pl_rsp_reg   <= pl_reg;
      pl_rsp_data  <= exp_pl;
      bk_rd_valid  <= pl_valid && !hit_p;
      bk_rd_warp   <= pl_warp;
      bk_rd_reg    <= pl_reg;
      bk_wr_valid  <= (ev_valid && !comp) || victim_wb;
      if (victim_wb) begin
        {bk_wr_warp, bk_wr_reg} <= tag_q[victim_idx];
        bk_wr_data              <= exp_vic;
      end else begin
        bk_wr_warp <= ev_warp;
        bk_wr_reg  <= ev_reg;
        bk_wr_data <= ev_data;
      end
    end
  end
endmodule

// File: rtl/ecmp_checker.sv
module ecmp_checker #(
  parameter int WARP_W = 5,
  parameter int LINES  = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              pl_valid,
  input logic [WARP_W-1:0] pl_warp,
  input logic              pl_rsp_valid,
  input logic              pl_rsp_hit,
  input logic              bk_wr_valid,
  input logic              bk_rd_valid,
  input logic [WARP_W-1:0] bk_rd_warp,
  input logic [LINES-1:0]  line_valid,
  input logic [LINES-1:0]  ev_match_vec,
  input logic              victim_wb
);
  assert_wr_follows_evict_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bk_wr_valid |-> $past(ev_valid));

  assert_rsp_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |=> pl_rsp_valid);

  assert_rd_only_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bk_rd_valid |-> (pl_rsp_valid && !pl_rsp_hit));

  assert_rd_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bk_rd_valid |-> (bk_rd_warp == $past(pl_warp)));

  assert_tag_unique_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_match_vec));

  assert_victim_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_wb |-> ($countones(line_valid) == LINES));
endmodule

bind evict_pattern_comp ecmp_checker #(.WARP_W(WARP_W), .LINES(LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .pl_valid(pl_valid), .pl_warp(pl_warp),
  .pl_rsp_valid(pl_rsp_valid), .pl_rsp_hit(pl_rsp_hit), .bk_wr_valid(bk_wr_valid),
  .bk_rd_valid(bk_rd_valid), .bk_rd_warp(bk_rd_warp), .line_valid(valid_q),
  .ev_match_vec(ev_vec), .victim_wb(victim_wb));

// File: tb/evict_pattern_comp_tb_top.sv
`timescale 1ns/1ps
module evict_pattern_comp_tb_top;
  localparam int LANES = 8, DW = 32, LINES = 48, WW = 5, RW = 6;
  localparam int TW = WW + RW, VW = LANES * DW;
  typedef logic [VW-1:0] vec_t;
  typedef logic [TW-1:0] tag_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          ev_valid = 0, pl_valid = 0;
  logic [WW-1:0] ev_warp = '0, pl_warp = '0;
  logic [RW-1:0] ev_reg = '0, pl_reg = '0;
  vec_t          ev_data = '0;
  logic          pl_rsp_valid, pl_rsp_hit, bk_wr_valid, bk_rd_valid;
  logic [WW-1:0] pl_rsp_warp, bk_wr_warp, bk_rd_warp;
  logic [RW-1:0] pl_rsp_reg, bk_wr_reg, bk_rd_reg;
  vec_t          pl_rsp_data, bk_wr_data;

  evict_pattern_comp #(.LANES(LANES), .DW(DW), .LINES(LINES), .WARP_W(WW), .REG_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_warp(ev_warp), .ev_reg(ev_reg),
    .ev_data(ev_data), .pl_valid(pl_valid), .pl_warp(pl_warp), .pl_reg(pl_reg),
    .pl_rsp_valid(pl_rsp_valid), .pl_rsp_hit(pl_rsp_hit), .pl_rsp_warp(pl_rsp_warp),
    .pl_rsp_reg(pl_rsp_reg), .pl_rsp_data(pl_rsp_data), .bk_wr_valid(bk_wr_valid),
    .bk_wr_warp(bk_wr_warp), .bk_wr_reg(bk_wr_reg), .bk_wr_data(bk_wr_data),
    .bk_rd_valid(bk_rd_valid), .bk_rd_warp(bk_rd_warp), .bk_rd_reg(bk_rd_reg));

  int n_checks = 0, n_errors = 0, cyc_n = 0;

  task automatic check(input bit ok, input string req, input string msg);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // reference model: resident values in write order, oldest first
  tag_t m_tag[$];
  vec_t m_dat[$];

  // expectation queues, stamped with the monitor cycle they are due in
  int    wr_at[$];  tag_t wr_tag[$];  vec_t wr_dat[$];  string wr_req[$];
  int    rd_at[$];  tag_t rd_tag[$];  string rd_req[$];
  int    rs_at[$];  tag_t rs_tag[$];  bit rs_hit[$];  vec_t rs_dat[$];  string rs_req[$];

  function automatic int m_find(input tag_t t);
    for (int k = 0; k < m_tag.size(); k++) if (m_tag[k] == t) return k;
    return -1;
  endfunction

  // compressible when zero, or when every neighbouring lane difference is equal
  function automatic bit is_comp(input vec_t d);
    logic [DW-1:0] step;
    if (d == '0) return 1'b1;
    step = d[DW +: DW] - d[0 +: DW];
    for (int i = 2; i < LANES; i++)
      if (d[i*DW +: DW] - d[(i-1)*DW +: DW] != step) return 1'b0;
    return 1'b1;
  endfunction

  function automatic vec_t mk_seq(input logic [DW-1:0] b, input logic [DW-1:0] s);
    vec_t v;
    logic [DW-1:0] x;
    x = b;
    for (int i = 0; i < LANES; i++) begin
      v[i*DW +: DW] = x;
      x = x + s;
    end
    return v;
  endfunction

  function automatic vec_t mk_rand();
    vec_t v;
    for (int i = 0; i < LANES; i++) v[i*DW +: DW] = $urandom;
    return v;
  endfunction

  // driver: one cycle of stimulus plus the expectations it implies
  task automatic cyc(input bit ev, input tag_t et, input vec_t ed,
                     input bit pl, input tag_t pt, input string req);
    int k;
    int due;
    bit c;
    @(negedge clk);
    #2;
    due = cyc_n + 1;
    ev_valid = ev; {ev_warp, ev_reg} = et; ev_data = ed;
    pl_valid = pl; {pl_warp, pl_reg} = pt;
    if (pl) begin
      k = m_find(pt);
      rs_at.push_back(due); rs_tag.push_back(pt); rs_req.push_back(req);
      if (k >= 0) begin
        rs_hit.push_back(1'b1); rs_dat.push_back(m_dat[k]);
        if (!(ev && et == pt)) begin m_tag.delete(k); m_dat.delete(k); end
      end else begin
        rs_hit.push_back(1'b0); rs_dat.push_back('0);
        rd_at.push_back(due); rd_tag.push_back(pt); rd_req.push_back(req);
      end
    end
    if (ev) begin
      c = is_comp(ed);
      k = m_find(et);
      if (k >= 0) begin m_tag.delete(k); m_dat.delete(k); end
      if (c) begin
        if (k < 0 && m_tag.size() == LINES) begin
          wr_at.push_back(due); wr_tag.push_back(m_tag[0]);
          wr_dat.push_back(m_dat[0]); wr_req.push_back(req);
          m_tag.delete(0); m_dat.delete(0);
        end
        m_tag.push_back(et); m_dat.push_back(ed);
      end else begin
        wr_at.push_back(due); wr_tag.push_back(et); wr_dat.push_back(ed); wr_req.push_back(req);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, '0, "idle");
  endtask

  // monitor: compares outputs against the queues at the negative edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc_n++;
      if (wr_at.size() > 0 && wr_at[0] == cyc_n) begin
        check(bk_wr_valid === 1'b1 && {bk_wr_warp, bk_wr_reg} === wr_tag[0] &&
              bk_wr_data === wr_dat[0], wr_req[0],
              $sformatf("backing write v=%b tag=%h data=%h expected tag=%h data=%h",
                        bk_wr_valid, {bk_wr_warp, bk_wr_reg}, bk_wr_data, wr_tag[0], wr_dat[0]));
        void'(wr_at.pop_front()); void'(wr_tag.pop_front());
        void'(wr_dat.pop_front()); void'(wr_req.pop_front());
      end else if (bk_wr_valid !== 1'b0)
        check(1'b0, "R4", $sformatf("unexpected backing write tag=%h expected none",
                                    {bk_wr_warp, bk_wr_reg}));
      if (rd_at.size() > 0 && rd_at[0] == cyc_n) begin
        check(bk_rd_valid === 1'b1 && {bk_rd_warp, bk_rd_reg} === rd_tag[0], rd_req[0],
              $sformatf("backing read v=%b tag=%h expected tag=%h",
                        bk_rd_valid, {bk_rd_warp, bk_rd_reg}, rd_tag[0]));
        void'(rd_at.pop_front()); void'(rd_tag.pop_front()); void'(rd_req.pop_front());
      end else if (bk_rd_valid !== 1'b0)
        check(1'b0, "R5", $sformatf("unexpected backing read tag=%h expected none",
                                    {bk_rd_warp, bk_rd_reg}));
      if (rs_at.size() > 0 && rs_at[0] == cyc_n) begin
        check(pl_rsp_valid === 1'b1 && pl_rsp_hit === rs_hit[0] &&
              {pl_rsp_warp, pl_rsp_reg} === rs_tag[0] &&
              (!rs_hit[0] || pl_rsp_data === rs_dat[0]), rs_req[0],
              $sformatf("response v=%b hit=%b tag=%h data=%h expected hit=%b tag=%h data=%h",
                        pl_rsp_valid, pl_rsp_hit, {pl_rsp_warp, pl_rsp_reg}, pl_rsp_data,
                        rs_hit[0], rs_tag[0], rs_dat[0]));
        void'(rs_at.pop_front()); void'(rs_tag.pop_front()); void'(rs_hit.pop_front());
        void'(rs_dat.pop_front()); void'(rs_req.pop_front());
      end else if (pl_rsp_valid !== 1'b0)
        check(1'b0, "R11", $sformatf("unexpected response v=%b expected 0", pl_rsp_valid));
    end
  end

  bit finished = 0;
  initial begin
    #(20 * 150000);
    if (!finished) begin
      check(1'b0, "watchdog", "run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    vec_t v, w;
    repeat (3) @(negedge clk);
    // R1: reset state of the outputs
    check(pl_rsp_valid === 0 && bk_wr_valid === 0 && bk_rd_valid === 0, "R1",
          $sformatf("strobes rsp=%b wr=%b rd=%b expected 000", pl_rsp_valid, bk_wr_valid, bk_rd_valid));
    #2 rst_n = 1'b1;

    // R1 R5: empty store misses
    cyc(0, '0, '0, 1, 11'h015, "R1");
    cyc(0, '0, '0, 1, 11'h7ff, "R5");
    idle(2);

    // R2 R6: zero value kept, hit, then freed
    cyc(1, 11'h021, '0, 0, '0, "R2");
    idle(1);
    cyc(0, '0, '0, 1, 11'h021, "R2");
    cyc(0, '0, '0, 1, 11'h021, "R6");

    // R3: plain, wrapping and negative strides
    cyc(1, 11'h030, mk_seq(32'd0, 32'd4), 0, '0, "R3");
    cyc(1, 11'h031, mk_seq(32'hFFFF_FFF0, 32'h1000_0003), 0, '0, "R3");
    cyc(1, 11'h032, mk_seq(32'd100, 32'hFFFF_FFF9), 0, '0, "R3");
    cyc(1, 11'h033, mk_seq(32'h1234_5678, 32'd0), 0, '0, "R3");
    cyc(0, '0, '0, 1, 11'h030, "R3");
    cyc(0, '0, '0, 1, 11'h031, "R3");
    cyc(0, '0, '0, 1, 11'h032, "R3");
    cyc(0, '0, '0, 1, 11'h033, "R3");

    // R4: incompressible and near-miss values forwarded
    cyc(1, 11'h040, mk_rand(), 0, '0, "R4");
    v = mk_seq(32'd8, 32'd8); v[(LANES-1)*DW +: DW] = v[(LANES-1)*DW +: DW] + 1;
    cyc(1, 11'h041, v, 0, '0, "R4");
    w = '0; w[3*DW +: DW] = 32'd1;
    cyc(1, 11'h042, w, 1, 11'h042, "R4");
    idle(2);

    // R7: in-place update, then drop on incompressible re-eviction
    cyc(1, 11'h050, mk_seq(32'd1, 32'd2), 0, '0, "R7");
    cyc(1, 11'h050, mk_seq(32'd9, 32'd3), 0, '0, "R7");
    cyc(0, '0, '0, 1, 11'h050, "R7");
    cyc(1, 11'h051, mk_seq(32'd5, 32'd5), 0, '0, "R7");
    cyc(1, 11'h051, mk_rand(), 0, '0, "R7");
    cyc(0, '0, '0, 1, 11'h051, "R7");
    idle(2);

    // R8 R9: fill, refresh the oldest, overflow
    for (int t = 0; t < LINES; t++)
      cyc(1, tag_t'(256 + t), mk_seq(32'(t * 7), 32'(t + 1)), 0, '0, "R8");
    cyc(1, tag_t'(256), mk_seq(32'd77, 32'd1), 0, '0, "R9");
    cyc(1, tag_t'(512), mk_seq(32'd3, 32'd3), 0, '0, "R9");
    cyc(1, tag_t'(513), '0, 0, '0, "R8");
    cyc(0, '0, '0, 1, tag_t'(256), "R9");

    // R10: same-cycle preload and eviction
    cyc(1, tag_t'(514), mk_seq(32'd4, 32'd4), 0, '0, "R10");
    cyc(1, tag_t'(515), mk_seq(32'd6, 32'd6), 1, tag_t'(260), "R10");
    cyc(1, tag_t'(261), mk_seq(32'd50, 32'd2), 1, tag_t'(261), "R10");
    cyc(0, '0, '0, 1, tag_t'(261), "R10");
    cyc(1, tag_t'(262), mk_rand(), 1, tag_t'(262), "R10");
    cyc(0, '0, '0, 1, tag_t'(262), "R10");
    idle(2);

    // R11 plus all rules: random mix over a small tag pool
    for (int i = 0; i < 3000; i++) begin
      int kind;
      vec_t d;
      kind = $urandom_range(0, 3);
      d = (kind == 0) ? '0 : (kind == 1) ? mk_seq($urandom, $urandom) :
          (kind == 2) ? mk_seq($urandom_range(0, 3), $urandom_range(0, 2)) : mk_rand();
      cyc($urandom_range(0, 1), tag_t'($urandom_range(0, 15)), d,
          $urandom_range(0, 1), tag_t'($urandom_range(0, 15)), "R11");
    end
    idle(3);
    check(wr_at.size() == 0 && rd_at.size() == 0 && rs_at.size() == 0, "R11",
          $sformatf("pending expectations wr=%0d rd=%0d rsp=%0d expected 0",
                    wr_at.size(), rd_at.size(), rs_at.size()));
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule